// File: doc/BRIEF.md
# Processor Reset Sequencer with Configuration Strap Drive

This block lives on the system side of a processor socket and owns the processor reset line. When power is reported good, it runs a cold reset. When the system asks for a warm reset, it runs a shorter one. During each reset it drives a set of configuration straps that the processor samples when reset is released. These are a multi-bit bus-frequency strap plus two single-bit straps: a flush strap and a cache-ready strap. The block holds each strap for the required time on both sides of the release.

Each sequence has fixed phases. Reset is first held for a minimum width, which is one millisecond for a cold reset and a short clock count for a warm reset. Reset then stays asserted through a setup phase. In that phase the single-bit straps get their two-clock setup margin, and the frequency strap is checked to have been driven for a full millisecond. Reset is then negated. The straps are held through a short hold window. After that the block stops driving them and raises a release flag, so board logic can give the pins back to their normal use. The one-millisecond interval is counted in clocks, using a clock-rate parameter given in kHz.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, and afterwards for as long as `pwr_good` stays low, `cpu_reset` is 1, both strap enables are 0, every strap value output is 0, and `strap_release` and `running` are 0.
- R2: When `pwr_good` is sampled high in the idle state, a cold reset starts on that edge. `cpu_reset` stays high for exactly CLK_KHZ + SYNC_SETUP_CLKS clock cycles, counted from that edge.
- R3: A warm reset starts on the edge where `warm_req` is sampled high after reset negation. `cpu_reset` stays high for max(WARM_MIN_CLKS + SYNC_SETUP_CLKS, CLK_KHZ) cycles, counted from that edge.
- R4: The frequency strap carries the value of `freq_sel` captured on the edge that starts the reset. `strap_freq_oe` is 1 during every cycle in which `cpu_reset` is high, from that edge until negation.
- R5: The flush strap and the cache-ready strap carry `flush_sel` and `cready_sel`, captured on the same edge as the frequency strap. `strap_sync_oe` rises when the setup phase starts. It is 1 for exactly the last SYNC_SETUP_CLKS cycles before negation of a cold reset, and for the last R3-width − WARM_MIN_CLKS cycles before negation of a warm reset.
- R6: After `cpu_reset` falls, all straps stay driven with unchanged values for 1 + HOLD_CLKS cycles. In the next cycle, both enables drop, the value outputs read 0, and `strap_release` and `running` both become 1.
- R7: A `warm_req` sampled while `cpu_reset` is still high restarts the minimum-width count of the current reset from zero. The reset kind is kept (a restarted cold reset still waits CLK_KHZ cycles), and the strap values are not recaptured.
- R8: A `warm_req` sampled during the hold window starts a new warm reset on the next cycle. `cpu_reset` goes high again, and the straps are recaptured from the inputs.
- R9: `pwr_good` sampled low in any state returns the block to idle on the next cycle. Reset is asserted and the straps are undriven. A later `pwr_good` runs a full cold reset.
- R10: Changes on `freq_sel`, `flush_sel` and `cready_sel` after the capture edge have no effect on the strap outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| pwr_good | input | 1 | Supplies and clock are in specification |
| warm_req | input | 1 | Request for a warm reset (level, sampled each clock) |
| freq_sel | input | FREQ_W | Bus-frequency strap value to present |
| flush_sel | input | 1 | Flush strap value to present |
| cready_sel | input | 1 | Cache-ready strap value to present |
| cpu_reset | output | 1 | Processor reset, active high |
| strap_freq | output | FREQ_W | Frequency strap value (0 when not driven) |
| strap_flush | output | 1 | Flush strap value (0 when not driven) |
| strap_cready | output | 1 | Cache-ready strap value (0 when not driven) |
| strap_freq_oe | output | 1 | Frequency strap is being driven |
| strap_sync_oe | output | 1 | Flush and cache-ready straps are being driven |
| strap_release | output | 1 | Hold window is over; strap pins may return to normal use |
| running | output | 1 | Sequence complete, processor out of reset |

## Verification
Two situations are hard to reach from the ports. The first is a warm request that lands in the middle of a running reset. The second is a warm request that lands in the single cycle right after negation. Both need the request placed on an exact cycle, counted from the start of the sequence. The stimulus task counts sampled cycles of the asserted reset and raises the request on a chosen count. It then measures the lengthened width and checks that the straps kept their first values even though the inputs were scrambled. For the second case, the bench watches for the first cycle with reset low and raises the request right there. The cold and warm widths differ by the frequency-strap rule, and the bench sets a one-millisecond count only five clocks longer than the warm minimum. A warm reset therefore has to stretch its setup phase, which shows the stretch in the width and in the sync-strap count.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ASSERT  = 3'd1,
    ST_SETUP   = 3'd2,
    ST_RELEASE = 3'd3,
    ST_HOLD    = 3'd4,
    ST_RUN     = 3'd5
  } rst_state_e;

  typedef enum logic {
    KIND_COLD = 1'b0,
    KIND_WARM = 1'b1
  } rst_kind_e;

endpackage

// File: rtl/rstseq_rst_sync.sv
module rstseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Cycles elapsed in the current window, saturating at limit-1.
  assign last = (cnt_q >= (limit - CW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!last) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: the count only moves forward between clears, so a window never wraps short.
  a_r2_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         oe,
  output logic [W-1:0] q
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= d;
    end
  end

  assign q = oe ? held_q : '0;

  // R10: once driven, the pin value moves only when a new capture happens.
  a_r10_latched_only: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !load) |=> (!oe || $stable(q)));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int CW        = 8,
  parameter int MS_CLKS   = 20,
  parameter int WARM_CLKS = 15,
  parameter int SYNC_CLKS = 2,
  parameter int HOLD_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          warm_req,
  input  logic          phase_last,
  input  logic          age_last,
  output logic          phase_clr,
  output logic [CW-1:0] phase_limit,
  output logic          latch_en,
  output logic          cpu_reset,
  output logic          freq_oe,
  output logic          sync_oe,
  output logic          strap_release,
  output logic          running
);

  rst_state_e state_q, state_d;
  rst_kind_e  kind_q,  kind_d;
  logic       restart;

  // Next-state process
  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    latch_en = 1'b0;
    restart  = 1'b0;
    if (!pwr_good) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d  = ST_ASSERT;
          kind_d   = KIND_COLD;
          latch_en = 1'b1;
        end
        ST_ASSERT: begin
          if (warm_req) begin
            restart = 1'b1;
          end else if (phase_last) begin
            state_d = ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (warm_req) begin
            state_d = ST_ASSERT;
            restart = 1'b1;
          end else if (phase_last && age_last) begin
            state_d = ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (warm_req) begin
            state_d  = ST_ASSERT;
            kind_d   = KIND_WARM;
            latch_en = 1'b1;
          end else begin
            state_d = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (warm_req) begin
            state_d  = ST_ASSERT;
            kind_d   = KIND_WARM;
            latch_en = 1'b1;
          end else if (phase_last) begin
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (warm_req) begin
            state_d  = ST_ASSERT;
            kind_d   = KIND_WARM;
            latch_en = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign phase_clr = restart || (state_d != state_q);

  // Window length for the phase in progress
  always_comb begin
    unique case (state_q)
      ST_ASSERT: phase_limit = (kind_q == KIND_COLD) ? CW'(MS_CLKS) : CW'(WARM_CLKS);
      ST_SETUP:  phase_limit = CW'(SYNC_CLKS);
      ST_HOLD:   phase_limit = CW'(HOLD_CLKS);
      default:   phase_limit = CW'(1);
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_COLD;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  assign cpu_reset     = (state_q == ST_IDLE) || (state_q == ST_ASSERT) || (state_q == ST_SETUP);
  assign freq_oe       = (state_q != ST_IDLE) && (state_q != ST_RUN);
  assign sync_oe       = (state_q == ST_SETUP) || (state_q == ST_RELEASE) || (state_q == ST_HOLD);
  assign running       = (state_q == ST_RUN);
  assign strap_release = (state_q == ST_RUN);

  // R7: a request during an active reset lands back at the start of the minimum width, same kind.
  a_r7_restart_keeps_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && warm_req && (state_q == ST_ASSERT || state_q == ST_SETUP))
    |=> (state_q == ST_ASSERT && kind_q == $past(kind_q)));

  // R2: reset only leaves the setup phase once the frequency strap has aged a full interval.
  a_r2_setup_waits_age: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && !age_last && pwr_good && !warm_req) |=> cpu_reset);

endmodule

// File: rtl/cpu_reset_sequencer.sv
module cpu_reset_sequencer #(
  parameter int CLK_KHZ         = 200000,
  parameter int WARM_MIN_CLKS   = 15,
  parameter int SYNC_SETUP_CLKS = 2,
  parameter int HOLD_CLKS       = 2,
  parameter int FREQ_W          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              warm_req,
  input  logic [FREQ_W-1:0] freq_sel,
  input  logic              flush_sel,
  input  logic              cready_sel,
  output logic              cpu_reset,
  output logic [FREQ_W-1:0] strap_freq,
  output logic              strap_flush,
  output logic              strap_cready,
  output logic              strap_freq_oe,
  output logic              strap_sync_oe,
  output logic              strap_release,
  output logic              running
);

  localparam int MS_CLKS  = CLK_KHZ;
  localparam int LIM_A    = (MS_CLKS > WARM_MIN_CLKS) ? MS_CLKS : WARM_MIN_CLKS;
  localparam int LIM_B    = (SYNC_SETUP_CLKS > HOLD_CLKS) ? SYNC_SETUP_CLKS : HOLD_CLKS;
  localparam int MAX_LIM  = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CW       = $clog2(MAX_LIM + 1);

  logic          rst_int_n;
  logic          phase_clr, phase_last, age_last, latch_en;
  logic [CW-1:0] phase_limit;
  logic [1:0]    sync_q;

  rstseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rstseq_ctrl #(
    .CW        (CW),
    .MS_CLKS   (MS_CLKS),
    .WARM_CLKS (WARM_MIN_CLKS),
    .SYNC_CLKS (SYNC_SETUP_CLKS),
    .HOLD_CLKS (HOLD_CLKS)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .pwr_good      (pwr_good),
    .warm_req      (warm_req),
    .phase_last    (phase_last),
    .age_last      (age_last),
    .phase_clr     (phase_clr),
    .phase_limit   (phase_limit),
    .latch_en      (latch_en),
    .cpu_reset     (cpu_reset),
    .freq_oe       (strap_freq_oe),
    .sync_oe       (strap_sync_oe),
    .strap_release (strap_release),
    .running       (running)
  );

  // Length of the phase in progress
  rstseq_timer #(.CW(CW)) u_phase_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (phase_clr),
    .limit (phase_limit),
    .last  (phase_last)
  );

  // Time the frequency strap has been on the pins since capture
  rstseq_timer #(.CW(CW)) u_age_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (latch_en),
    .limit (CW'(MS_CLKS)),
    .last  (age_last)
  );

  rstseq_strap #(.W(FREQ_W)) u_freq_strap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (latch_en),
    .d     (freq_sel),
    .oe    (strap_freq_oe),
    .q     (strap_freq)
  );

  rstseq_strap #(.W(2)) u_sync_strap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (latch_en),
    .d     ({flush_sel, cready_sel}),
    .oe    (strap_sync_oe),
    .q     (sync_q)
  );

  assign strap_flush  = sync_q[1];
  assign strap_cready = sync_q[0];

  // R4, R5: every strap is on the pins at the moment reset is negated.
  a_r4_straps_at_negation: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset) |-> (strap_freq_oe && strap_sync_oe));

  // R5: the short-setup straps are only ever driven inside the frequency strap window.
  a_r5_sync_nested: assert property (@(posedge clk) disable iff (!rst_n)
    strap_sync_oe |-> strap_freq_oe);

  // R6: values hold still in the cycle after negation unless a new sequence begins.
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_reset) && !warm_req && pwr_good)
    |=> (strap_freq_oe && strap_sync_oe && $stable(strap_freq) && $stable(sync_q)));

  // R6: the release flag comes up only with the pins undriven and reset negated.
  a_r6_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_release) |-> (!strap_freq_oe && !strap_sync_oe && !cpu_reset && running));

  // R9: loss of power-good puts reset back on and the straps off the pins.
  a_r9_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good) |=> (cpu_reset && !strap_freq_oe && !running));

endmodule

// File: tb/cpu_reset_sequencer_test.sv
`timescale 1ns/1ps
module cpu_reset_sequencer_test;

  localparam int MS   = 20;
  localparam int WARM = 15;
  localparam int SYNC = 2;
  localparam int HOLD = 2;
  localparam int EXP_COLD = MS + SYNC;
  localparam int EXP_WARM = (WARM + SYNC > MS) ? (WARM + SYNC) : MS;
  localparam int EXP_HOLD = 1 + HOLD;

  // {warm, freq[2:0], flush, cready}
  localparam int NVEC = 6;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_101_1_0,
    6'b1_010_0_1,
    6'b1_111_1_1,
    6'b0_000_0_0,
    6'b1_001_1_0,
    6'b0_110_0_1
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_good, warm_req;
  logic [2:0] freq_sel;
  logic       flush_sel, cready_sel;
  logic       cpu_reset;
  logic [2:0] strap_freq;
  logic       strap_flush, strap_cready;
  logic       strap_freq_oe, strap_sync_oe, strap_release, running;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cpu_reset_sequencer #(
    .CLK_KHZ         (MS),
    .WARM_MIN_CLKS   (WARM),
    .SYNC_SETUP_CLKS (SYNC),
    .HOLD_CLKS       (HOLD),
    .FREQ_W          (3)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good      (pwr_good),
    .warm_req      (warm_req),
    .freq_sel      (freq_sel),
    .flush_sel     (flush_sel),
    .cready_sel    (cready_sel),
    .cpu_reset     (cpu_reset),
    .strap_freq    (strap_freq),
    .strap_flush   (strap_flush),
    .strap_cready  (strap_cready),
    .strap_freq_oe (strap_freq_oe),
    .strap_sync_oe (strap_sync_oe),
    .strap_release (strap_release),
    .running       (running)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts one reset (cold through a power-good drop, warm through warm_req),
  // scrambles the strap inputs after capture, and measures the sequence.
  task automatic run_seq(input logic warm, input logic [2:0] f, input logic fl, input logic cr,
                         input int restart_at,
                         output int w, output int fc, output int sc, output int hc,
                         output logic [2:0] f_at, output logic fl_at, output logic cr_at,
                         output int stab, output int rel);
    freq_sel = f; flush_sel = fl; cready_sel = cr;
    if (warm) begin
      warm_req = 1'b1;
      @(negedge clk);
      warm_req = 1'b0;
    end else begin
      pwr_good = 1'b0;
      @(negedge clk);
      pwr_good = 1'b1;
      @(negedge clk);
    end
    freq_sel = ~f; flush_sel = ~fl; cready_sel = ~cr;
    w = 0; fc = 0; sc = 0;
    while (cpu_reset === 1'b1 && w < 1000) begin
      w++;
      if (strap_freq_oe) fc++;
      if (strap_sync_oe) sc++;
      warm_req = (w == restart_at);
      @(negedge clk);
    end
    warm_req = 1'b0;
    f_at = strap_freq; fl_at = strap_flush; cr_at = strap_cready;
    hc = 0; stab = 1;
    while (strap_freq_oe === 1'b1 && hc < 100) begin
      hc++;
      if (strap_freq != f_at || strap_flush != fl_at || strap_cready != cr_at || !strap_sync_oe)
        stab = 0;
      @(negedge clk);
    end
    rel = (strap_release && running && !strap_freq_oe && !strap_sync_oe && !cpu_reset &&
           strap_freq == 3'd0 && !strap_flush && !strap_cready) ? 1 : 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int w, fc, sc, hc, stab, rel;
    logic [2:0] f_at;
    logic fl_at, cr_at;

    rst_n = 1'b0; pwr_good = 1'b0; warm_req = 1'b0;
    freq_sel = 3'd0; flush_sel = 1'b0; cready_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset asserted in block reset", int'(cpu_reset), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 reset held while power not good", int'(cpu_reset), 1);
    chk("R1 straps undriven", int'({strap_freq_oe, strap_sync_oe}), 0);
    chk("R1 strap values zero", int'({strap_freq, strap_flush, strap_cready}), 0);
    chk("R1 release and running low", int'({strap_release, running}), 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic       vw;
      logic [2:0] vf;
      logic       vfl, vcr;
      int         ew;
      {vw, vf, vfl, vcr} = VEC[i];
      ew = vw ? EXP_WARM : EXP_COLD;
      run_seq(vw, vf, vfl, vcr, 0, w, fc, sc, hc, f_at, fl_at, cr_at, stab, rel);
      chk(vw ? "R3 warm reset width" : "R2 cold reset width", w, ew);
      chk("R4 freq strap driven through reset", fc, ew);
      chk("R5 sync strap setup cycles", sc, vw ? (ew - WARM) : SYNC);
      chk("R4 R10 freq strap value", int'(f_at), int'(vf));
      chk("R5 R10 flush and cache-ready values", int'({fl_at, cr_at}), int'({vfl, vcr}));
      chk("R6 hold window length", hc, EXP_HOLD);
      chk("R6 straps stable in hold", stab, 1);
      chk("R6 release state", rel, 1);
    end

    // R7: restart during the active cold reset, kind and straps kept
    run_seq(1'b0, 3'b011, 1'b1, 1'b0, 10, w, fc, sc, hc, f_at, fl_at, cr_at, stab, rel);
    chk("R7 restarted cold width", w, 10 + MS + SYNC);
    chk("R7 sync setup after restart", sc, SYNC);
    chk("R7 straps not recaptured", int'({f_at, fl_at, cr_at}), int'({3'b011, 1'b1, 1'b0}));
    chk("R7 release after restart", rel, 1);

    // R8: warm request in the first cycle after negation
    freq_sel = 3'b110; flush_sel = 1'b0; cready_sel = 1'b0;
    warm_req = 1'b1;
    @(negedge clk);
    warm_req = 1'b0;
    freq_sel = 3'b001; flush_sel = 1'b1; cready_sel = 1'b1;
    begin
      int g = 0;
      while (cpu_reset === 1'b1 && g < 1000) begin g++; @(negedge clk); end
    end
    // now in the first released cycle
    freq_sel = 3'b100; flush_sel = 1'b1; cready_sel = 1'b0;
    warm_req = 1'b1;
    @(negedge clk);
    warm_req = 1'b0;
    chk("R8 reset reasserted from hold window", int'(cpu_reset), 1);
    chk("R8 freq strap recaptured", int'(strap_freq), 3'b100);
    chk("R8 sync straps off during new assert", int'(strap_sync_oe), 0);
    begin
      int g = 0;
      while (running !== 1'b1 && g < 1000) begin g++; @(negedge clk); end
    end

    // R9: power loss mid-sequence, then a full cold reset
    pwr_good = 1'b0;
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (6) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R9 reset held on power loss", int'(cpu_reset), 1);
    chk("R9 straps dropped on power loss", int'({strap_freq_oe, strap_sync_oe, running}), 0);
    run_seq(1'b0, 3'b010, 1'b1, 1'b1, 0, w, fc, sc, hc, f_at, fl_at, cr_at, stab, rel);
    chk("R9 full cold width after power return", w, EXP_COLD);
    chk("R9 release after power return", rel, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule